// File: doc/BRIEF.md
# Descriptor-Chained Memory-to-Stream DMA Channel

This block is a single outbound DMA channel. Once started with the address of a first data descriptor and the address of a context record, it walks a linked list of four-word descriptors held in memory. For each descriptor it streams, one byte per beat, every byte from the current buffer position up to (but not including) the descriptor's end pointer. Each descriptor is split into chunks of at most `CHUNK_MAX` bytes. A 16-bit metadata word goes out on a side channel at the start of every packet. Each finished descriptor is written back to memory, and the channel then follows the next pointer.

When a descriptor flagged end-of-list completes, the channel does three things. It performs a read-modify-write on the context record's flags word to set its disable bit. It raises its end-of-list state. It then issues no further memory traffic until it is started again. The block has one memory request port with a valid/ready handshake and a separate read-response strobe. It also has a byte-stream output with an end-of-packet marker, a metadata output with its own handshake, and a one-cycle interrupt-set pulse. The current descriptor address and buffer position are visible as outputs.

Top module: `dma_out_chan`

## Requirements
- R1: After reset the channel is idle: no memory request, no stream or metadata valid, `irq_set_o`, `busy_o` and `eol_o` all low.
- R2: On `start_i` while not busy, the channel fetches the four descriptor words (next pointer, buffer start, flags, end pointer) at byte offsets 0, 4, 8 and 12 from `desc_addr_i`, using word reads.
- R3: The bytes of the range [buffer start, end pointer) are sent in ascending address order. Each byte is taken from the little-endian lane selected by the low two bits of its address.
- R4: A descriptor is sent in chunks of at most `CHUNK_MAX` bytes. `cur_pos_o` advances to the end of each chunk when that chunk finishes, and it is loaded with the buffer start when a descriptor is fetched.
- R5: `st_eop_o` is high only on the final byte of a descriptor whose flags bit 3 (output end-of-packet) is set, and low on every other byte.
- R6: Flags bits 31:16 are sent on the metadata port before the first byte after a start. They are sent again before the first byte that follows the completion of a descriptor with flags bit 3 set, and at no other time.
- R7: When a descriptor with flags bit 4 (interrupt-on-done) completes, `irq_set_o` pulses high for exactly one cycle. This pulse is the request to set interrupt status bit 2.
- R8: Each completed descriptor is written back as four word writes to the same four addresses it was fetched from.
- R9: A completed descriptor without flags bit 0 (end-of-list) makes its next pointer the current descriptor address (`cur_desc_o`), and that descriptor is fetched next.
- R10: On completing a descriptor with flags bit 0 set, the channel reads the word at context address + 4, writes it back with bit 15 (disable) set, raises `eol_o`, and then issues no memory request until the next start.
- R11: A descriptor whose buffer start equals its end pointer produces no stream beat, but it still completes, with its interrupt, write-back and chaining.
- R12: While `st_valid_o` is high and `st_ready_i` is low, `st_valid_o`, `st_data_o` and `st_eop_o` hold. While `md_valid_o` is high and `md_ready_i` is low, `md_valid_o` and `md_data_o` hold.
- R13: A start accepted while idle or halted clears `eol_o` and makes the channel busy from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, honoured while not busy |
| desc_addr_i | input | AW | Byte address of the first descriptor |
| ctx_addr_i | input | AW | Byte address of the context record |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_we_o | output | 1 | 1 = write, 0 = read |
| mem_req_addr_o | output | AW | Word-aligned byte address |
| mem_req_wdata_o | output | 32 | Write data |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data |
| md_valid_o | output | 1 | Metadata valid |
| md_ready_i | input | 1 | Metadata accepted |
| md_data_o | output | 16 | Metadata word |
| st_valid_o | output | 1 | Stream byte valid |
| st_ready_i | input | 1 | Stream byte accepted |
| st_data_o | output | 8 | Stream byte |
| st_eop_o | output | 1 | End-of-packet marker on this byte |
| irq_set_o | output | 1 | One-cycle request to set interrupt status bit 2 |
| busy_o | output | 1 | Channel is walking the list |
| eol_o | output | 1 | End-of-list reached |
| cur_desc_o | output | AW | Current descriptor address |
| cur_pos_o | output | AW | Current buffer position |

## Verification
Two cases are hard to reach from the ports. The first is a zero-length descriptor sitting in the middle of a chain, where no byte appears but the interrupt, the write-back and the chaining must still happen. The second is a descriptor longer than one chunk, whose intermediate positions show only on `cur_pos_o`. The stimulus builds a three-descriptor chain in the bench memory model: a 40-byte descriptor with a reduced chunk limit of 16, then an empty descriptor with its interrupt bit set, then a short end-of-list descriptor. Throughout, pseudo-random ready patterns on memory, stream and metadata force stalls at every handshake. A second packet-per-descriptor chain then checks that metadata is re-sent after each end-of-packet completion.

// File: rtl/dma_out_pkg.sv
package dma_out_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FREQ,
        S_FWAIT,
        S_META,
        S_CSET,
        S_RREQ,
        S_RWAIT,
        S_PUSH,
        S_CEND,
        S_WB,
        S_XRREQ,
        S_XRWAIT,
        S_XWR,
        S_HALT
    } chan_st_e;

    // descriptor word indices
    localparam int unsigned W_NEXT  = 0;
    localparam int unsigned W_BUF   = 1;
    localparam int unsigned W_FLAGS = 2;
    localparam int unsigned W_END   = 3;

    // flags word bit positions
    localparam int unsigned F_LAST  = 0;
    localparam int unsigned F_OEOP  = 3;
    localparam int unsigned F_INTR  = 4;
    localparam int unsigned F_MD_LO = 16;
    localparam int unsigned CTX_DIS = 15;

endpackage

// File: rtl/dma_out_chunk.sv
module dma_out_chunk #(
    parameter int unsigned AW        = 32,
    parameter int unsigned CHUNK_MAX = 2048,
    parameter int unsigned CW        = 12
) (
    input  logic [AW-1:0] pos_i,
    input  logic [AW-1:0] end_i,
    input  logic          oeop_i,
    output logic [CW-1:0] len_o,
    output logic          eop_o
);
    logic [AW-1:0] rem;
    logic          big;

    always_comb begin
        rem   = end_i - pos_i;
        big   = rem > AW'(CHUNK_MAX);
        len_o = big ? CW'(CHUNK_MAX) : rem[CW-1:0];
        eop_o = !big && oeop_i && (rem != '0);
    end
endmodule

// File: rtl/dma_out_lane.sv
module dma_out_lane (
    input  logic [31:0] word_i,
    input  logic [1:0]  sel_i,
    output logic [7:0]  lane_o
);
    logic [3:0][7:0] lanes;

    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign lanes[g] = word_i[8*g +: 8];
    end

    assign lane_o = lanes[sel_i];
endmodule

// File: rtl/dma_out_chan.sv
module dma_out_chan
    import dma_out_pkg::*;
#(
    parameter int unsigned AW        = 32,
    parameter int unsigned CHUNK_MAX = 2048
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] desc_addr_i,
    input  logic [AW-1:0] ctx_addr_i,
    output logic          mem_req_valid_o,
    input  logic          mem_req_ready_i,
    output logic          mem_req_we_o,
    output logic [AW-1:0] mem_req_addr_o,
    output logic [31:0]   mem_req_wdata_o,
    input  logic          mem_rsp_valid_i,
    input  logic [31:0]   mem_rsp_data_i,
    output logic          md_valid_o,
    input  logic          md_ready_i,
    output logic [15:0]   md_data_o,
    output logic          st_valid_o,
    input  logic          st_ready_i,
    output logic [7:0]    st_data_o,
    output logic          st_eop_o,
    output logic          irq_set_o,
    output logic          busy_o,
    output logic          eol_o,
    output logic [AW-1:0] cur_desc_o,
    output logic [AW-1:0] cur_pos_o
);
    localparam int unsigned CW = $clog2(CHUNK_MAX + 1);

    typedef struct packed {
        chan_st_e        st;
        logic [1:0]      idx;
        logic [3:0][31:0] dsc;
        logic [AW-1:0]   cur_desc;
        logic [AW-1:0]   cur_pos;
        logic [AW-1:0]   rd_addr;
        logic [AW-1:0]   ctx_base;
        logic [CW-1:0]   left;
        logic            ceop;
        logic            smd;
        logic            eol;
        logic            irq;
        logic            cvld;
        logic [AW-3:0]   caddr;
        logic [31:0]     cdata;
        logic [31:0]     ctx;
    } regs_t;

    regs_t q, d;

    logic [CW-1:0] chunk_len;
    logic          chunk_eop;
    logic [7:0]    lane_byte;
    logic [31:0]   flags;
    logic [AW-1:0] end_ptr;
    logic          cache_hit;

    assign flags   = q.dsc[W_FLAGS];
    assign end_ptr = q.dsc[W_END][AW-1:0];

    dma_out_chunk #(.AW(AW), .CHUNK_MAX(CHUNK_MAX), .CW(CW)) u_chunk (
        .pos_i  (q.cur_pos),
        .end_i  (end_ptr),
        .oeop_i (flags[F_OEOP]),
        .len_o  (chunk_len),
        .eop_o  (chunk_eop)
    );

    dma_out_lane u_lane (
        .word_i (q.cdata),
        .sel_i  (q.rd_addr[1:0]),
        .lane_o (lane_byte)
    );

    assign cache_hit = q.cvld && (q.caddr == q.rd_addr[AW-1:2]);

    always_comb begin
        d               = q;
        d.irq           = 1'b0;
        mem_req_valid_o = 1'b0;
        mem_req_we_o    = 1'b0;
        mem_req_addr_o  = '0;
        mem_req_wdata_o = '0;
        md_valid_o      = 1'b0;
        md_data_o       = flags[F_MD_LO +: 16];
        st_valid_o      = 1'b0;
        st_data_o       = lane_byte;
        st_eop_o        = 1'b0;

        unique case (q.st)
            S_IDLE, S_HALT: begin
                if (start_i) begin
                    d.cur_desc = desc_addr_i;
                    d.ctx_base = ctx_addr_i;
                    d.idx      = '0;
                    d.smd      = 1'b1;
                    d.eol      = 1'b0;
                    d.cvld     = 1'b0;
                    d.st       = S_FREQ;
                end
            end
            S_FREQ: begin
                mem_req_valid_o = 1'b1;
                mem_req_addr_o  = q.cur_desc + AW'({q.idx, 2'b00});
                if (mem_req_ready_i) d.st = S_FWAIT;
            end
            S_FWAIT: begin
                if (mem_rsp_valid_i) begin
                    d.dsc[q.idx] = mem_rsp_data_i;
                    if (q.idx == 2'd3) begin
                        d.idx     = '0;
                        d.cur_pos = q.dsc[W_BUF][AW-1:0];
                        d.st      = q.smd ? S_META : S_CSET;
                    end else begin
                        d.idx = q.idx + 2'd1;
                        d.st  = S_FREQ;
                    end
                end
            end
            S_META: begin
                md_valid_o = 1'b1;
                if (md_ready_i) begin
                    d.smd = 1'b0;
                    d.st  = S_CSET;
                end
            end
            S_CSET: begin
                d.rd_addr = q.cur_pos;
                d.left    = chunk_len;
                d.ceop    = chunk_eop;
                d.st      = (chunk_len == '0) ? S_CEND : S_RREQ;
            end
            S_RREQ: begin
                if (cache_hit) begin
                    d.st = S_PUSH;
                end else begin
                    mem_req_valid_o = 1'b1;
                    mem_req_addr_o  = {q.rd_addr[AW-1:2], 2'b00};
                    if (mem_req_ready_i) d.st = S_RWAIT;
                end
            end
            S_RWAIT: begin
                if (mem_rsp_valid_i) begin
                    d.cvld  = 1'b1;
                    d.caddr = q.rd_addr[AW-1:2];
                    d.cdata = mem_rsp_data_i;
                    d.st    = S_PUSH;
                end
            end
            S_PUSH: begin
                st_valid_o = 1'b1;
                st_eop_o   = q.ceop && (q.left == CW'(1));
                if (st_ready_i) begin
                    d.rd_addr = q.rd_addr + AW'(1);
                    d.left    = q.left - CW'(1);
                    if (q.left == CW'(1))          d.st = S_CEND;
                    else if (q.rd_addr[1:0] == 2'd3) d.st = S_RREQ;
                end
            end
            S_CEND: begin
                d.cur_pos = q.rd_addr;
                if (q.rd_addr == end_ptr) begin
                    d.irq = flags[F_INTR];
                    if (flags[F_OEOP]) d.smd = 1'b1;
                    d.idx = '0;
                    d.st  = S_WB;
                end else begin
                    d.st = S_CSET;
                end
            end
            S_WB: begin
                mem_req_valid_o = 1'b1;
                mem_req_we_o    = 1'b1;
                mem_req_addr_o  = q.cur_desc + AW'({q.idx, 2'b00});
                mem_req_wdata_o = q.dsc[q.idx];
                if (mem_req_ready_i) begin
                    if (q.idx == 2'd3) begin
                        d.idx = '0;
                        if (flags[F_LAST]) begin
                            d.st = S_XRREQ;
                        end else begin
                            d.cur_desc = q.dsc[W_NEXT][AW-1:0];
                            d.st       = S_FREQ;
                        end
                    end else begin
                        d.idx = q.idx + 2'd1;
                    end
                end
            end
            S_XRREQ: begin
                mem_req_valid_o = 1'b1;
                mem_req_addr_o  = q.ctx_base + AW'(4);
                if (mem_req_ready_i) d.st = S_XRWAIT;
            end
            S_XRWAIT: begin
                if (mem_rsp_valid_i) begin
                    d.ctx          = mem_rsp_data_i;
                    d.ctx[CTX_DIS] = 1'b1;
                    d.st           = S_XWR;
                end
            end
            S_XWR: begin
                mem_req_valid_o = 1'b1;
                mem_req_we_o    = 1'b1;
                mem_req_addr_o  = q.ctx_base + AW'(4);
                mem_req_wdata_o = q.ctx;
                if (mem_req_ready_i) begin
                    d.eol = 1'b1;
                    d.st  = S_HALT;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign irq_set_o  = q.irq;
    assign busy_o     = (q.st != S_IDLE) && (q.st != S_HALT);
    assign eol_o      = q.eol;
    assign cur_desc_o = q.cur_desc;
    assign cur_pos_o  = q.cur_pos;
endmodule

// File: rtl/dma_out_chan_chk.sv
module dma_out_chan_chk #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          mem_req_valid_o,
    input logic          md_valid_o,
    input logic          md_ready_i,
    input logic [15:0]   md_data_o,
    input logic          st_valid_o,
    input logic          st_ready_i,
    input logic [7:0]    st_data_o,
    input logic          st_eop_o,
    input logic          irq_set_o,
    input logic          busy_o,
    input logic          eol_o
);
    // R12: stalled stream beat holds
    a_r12_stream_hold: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid_o && !st_ready_i |=> st_valid_o && $stable(st_data_o) && $stable(st_eop_o));

    // R12: stalled metadata holds
    a_r12_md_hold: assert property (@(posedge clk) disable iff (!rst_n)
        md_valid_o && !md_ready_i |=> md_valid_o && $stable(md_data_o));

    // R10: silent on the memory port after end-of-list
    a_r10_quiet_halt: assert property (@(posedge clk) disable iff (!rst_n)
        eol_o && !start_i |=> !mem_req_valid_o);

    // R7: interrupt request is a single-cycle pulse
    a_r7_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set_o |=> !irq_set_o);

    // R13: an accepted start clears end-of-list
    a_r13_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> busy_o && !eol_o);

    // R1: at most one outward request channel active at a time
    a_r1_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_valid_o, md_valid_o, mem_req_valid_o}));
endmodule

bind dma_out_chan dma_out_chan_chk #(.AW(AW)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .mem_req_valid_o (mem_req_valid_o),
    .md_valid_o      (md_valid_o),
    .md_ready_i      (md_ready_i),
    .md_data_o       (md_data_o),
    .st_valid_o      (st_valid_o),
    .st_ready_i      (st_ready_i),
    .st_data_o       (st_data_o),
    .st_eop_o        (st_eop_o),
    .irq_set_o       (irq_set_o),
    .busy_o          (busy_o),
    .eol_o           (eol_o)
);

// File: tb/dma_out_chan_bench.sv
module dma_out_chan_bench;
    localparam int unsigned AW = 32;
    localparam int unsigned CMAX = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] desc_addr_i = '0;
    logic [AW-1:0] ctx_addr_i = '0;
    logic          mem_req_valid_o;
    logic          mem_req_ready_i = 1'b0;
    logic          mem_req_we_o;
    logic [AW-1:0] mem_req_addr_o;
    logic [31:0]   mem_req_wdata_o;
    logic          mem_rsp_valid_i = 1'b0;
    logic [31:0]   mem_rsp_data_i = '0;
    logic          md_valid_o;
    logic          md_ready_i = 1'b0;
    logic [15:0]   md_data_o;
    logic          st_valid_o;
    logic          st_ready_i = 1'b0;
    logic [7:0]    st_data_o;
    logic          st_eop_o;
    logic          irq_set_o;
    logic          busy_o;
    logic          eol_o;
    logic [AW-1:0] cur_desc_o;
    logic [AW-1:0] cur_pos_o;

    always #5 clk = ~clk;

    dma_out_chan #(.AW(AW), .CHUNK_MAX(CMAX)) u_dma_out_chan (.*);

    logic [31:0] mem [0:1023];
    logic [17:0] exp_q[$];
    logic [31:0] pos_log[$];
    int          n_chk = 0;
    int          n_fail = 0;
    int          irq_cnt = 0;
    int          wr_cnt = 0;
    int          req_cnt = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic        pend = 1'b0;
    logic [9:0]  pend_idx = '0;
    logic        stall_q = 1'b0;
    logic [8:0]  stall_v = '0;
    logic [31:0] last_pos = '0;

    function automatic logic [7:0] bval(input logic [31:0] a);
        logic [7:0] t;
        t = a[7:0] * 8'd3;
        return t ^ 8'hA5;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // bench environment: ready patterns, memory model, scoreboard monitor
    always @(negedge clk) begin
        logic [17:0] it;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        st_ready_i      = lfsr[0] | lfsr[3];
        mem_req_ready_i = lfsr[5] | lfsr[1];
        md_ready_i      = lfsr[7] | lfsr[2];
        if (pend) begin
            mem_rsp_valid_i = 1'b1;
            mem_rsp_data_i  = mem[pend_idx];
            pend            = 1'b0;
        end else begin
            mem_rsp_valid_i = 1'b0;
        end
        if (rst_n && mem_req_valid_o && mem_req_ready_i) begin
            req_cnt++;
            if (mem_req_we_o) begin
                mem[mem_req_addr_o[11:2]] = mem_req_wdata_o;
                wr_cnt++;
            end else begin
                pend     = 1'b1;
                pend_idx = mem_req_addr_o[11:2];
            end
        end
        if (stall_q)
            chk(st_valid_o && {st_eop_o, st_data_o} == stall_v, "R12 stall hold",
                {23'd0, st_eop_o, st_data_o}, {23'd0, stall_v});
        stall_q = rst_n && st_valid_o && !st_ready_i;
        stall_v = {st_eop_o, st_data_o};
        if (rst_n && st_valid_o && st_ready_i) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected byte", {24'd0, st_data_o}, 32'd0);
            end else begin
                it = exp_q.pop_front();
                chk(!it[17], "R6 byte before metadata", 32'd0, 32'd1);
                chk(st_data_o == it[7:0], "R3 byte value", {24'd0, st_data_o}, {24'd0, it[7:0]});
                chk(st_eop_o == it[16], "R5 eop", {31'd0, st_eop_o}, {31'd0, it[16]});
            end
        end
        if (rst_n && md_valid_o && md_ready_i) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected metadata", {16'd0, md_data_o}, 32'd0);
            end else begin
                it = exp_q.pop_front();
                chk(it[17] && md_data_o == it[15:0], "R6 metadata",
                    {15'd0, 1'b1, md_data_o}, {15'd0, it[17], it[15:0]});
            end
        end
        if (rst_n && irq_set_o) irq_cnt++;
        if (rst_n && cur_pos_o != last_pos) pos_log.push_back(cur_pos_o);
        last_pos = cur_pos_o;
    end

    task automatic put_desc(input logic [31:0] a, input logic [31:0] nxt,
                            input logic [31:0] b, input logic [31:0] fl,
                            input logic [31:0] e);
        mem[a[11:2]]     = nxt;
        mem[a[11:2] + 1] = b;
        mem[a[11:2] + 2] = fl;
        mem[a[11:2] + 3] = e;
    endtask

    task automatic exp_bytes(input logic [31:0] b, input logic [31:0] e, input bit oeop);
        for (logic [31:0] a = b; a < e; a++)
            exp_q.push_back({1'b0, oeop && (a == e - 1), 8'h00, bval(a)});
    endtask

    task automatic exp_md(input logic [15:0] m);
        exp_q.push_back({1'b1, 1'b0, m});
    endtask

    task automatic run(input logic [31:0] first, input int exp_irq, input int exp_wr,
                       input logic [31:0] exp_last);
        int cyc;
        irq_cnt = 0;
        wr_cnt  = 0;
        mem[32'h104 >> 2] = 32'h0000_0081;
        @(negedge clk);
        desc_addr_i = first;
        ctx_addr_i  = 32'h100;
        start_i     = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o && !eol_o, "R13 start clears eol", {30'd0, busy_o, eol_o}, 32'd2);
        cyc = 0;
        while (!eol_o && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        chk(eol_o, "watchdog R10 eol", {31'd0, eol_o}, 32'd1);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all items seen", exp_q.size(), 32'd0);
        exp_q.delete();
        chk(irq_cnt == exp_irq, "R7 irq pulses", irq_cnt, exp_irq);
        chk(wr_cnt == exp_wr, "R8 write-backs", wr_cnt, exp_wr);
        chk(mem[32'h104 >> 2] == 32'h0000_8081, "R10 context disable bit",
            mem[32'h104 >> 2], 32'h0000_8081);
        chk(cur_desc_o == exp_last, "R9 last descriptor", cur_desc_o, exp_last);
        chk(!busy_o, "R10 halted", {31'd0, busy_o}, 32'd0);
    endtask

    initial begin
        logic [31:0] exp_pos[$];
        int r0;
        for (int i = 0; i < 1024; i++)
            mem[i] = {bval(4*i+3), bval(4*i+2), bval(4*i+1), bval(4*i)};
        repeat (3) @(negedge clk);
        chk(!mem_req_valid_o && !st_valid_o && !md_valid_o && !busy_o && !eol_o && !irq_set_o,
            "R1 reset state",
            {26'd0, mem_req_valid_o, st_valid_o, md_valid_o, busy_o, eol_o, irq_set_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // S1: single unaligned descriptor, eop + intr + end-of-list (R2 R3 R5 R7 R10)
        put_desc(32'h000, 32'h0, 32'h401, 32'hBEEF_0019, 32'h40B);
        exp_md(16'hBEEF);
        exp_bytes(32'h401, 32'h40B, 1'b1);
        run(32'h000, 1, 5, 32'h000);
        chk(mem[0] == 32'h0 && mem[2] == 32'hBEEF_0019 && mem[3] == 32'h40B,
            "R8 descriptor written unchanged", mem[2], 32'hBEEF_0019);

        // S2: chunked descriptor, empty descriptor, last descriptor (R4 R9 R11)
        put_desc(32'h020, 32'h040, 32'h500, 32'h1111_0000, 32'h528);
        put_desc(32'h040, 32'h060, 32'h600, 32'h2222_0010, 32'h600);
        put_desc(32'h060, 32'h000, 32'h700, 32'h3333_0009, 32'h707);
        exp_md(16'h1111);
        exp_bytes(32'h500, 32'h528, 1'b0);
        exp_bytes(32'h700, 32'h707, 1'b1);
        pos_log.delete();
        run(32'h020, 1, 13, 32'h060);
        exp_pos = '{32'h500, 32'h510, 32'h520, 32'h528, 32'h600, 32'h700, 32'h707};
        chk(pos_log.size() == exp_pos.size(), "R4 position updates", pos_log.size(), exp_pos.size());
        foreach (exp_pos[k])
            if (k < pos_log.size())
                chk(pos_log[k] == exp_pos[k], "R4 chunk position", pos_log[k], exp_pos[k]);

        // S3: two packets, metadata resent after eop descriptor (R6 R13)
        put_desc(32'h0C0, 32'h0D0, 32'h803, 32'hA0A0_0008, 32'h808);
        put_desc(32'h0D0, 32'h000, 32'h810, 32'hB0B0_0009, 32'h813);
        exp_md(16'hA0A0);
        exp_bytes(32'h803, 32'h808, 1'b1);
        exp_md(16'hB0B0);
        exp_bytes(32'h810, 32'h813, 1'b1);
        run(32'h0C0, 0, 9, 32'h0D0);

        // R10: no memory request while halted
        r0 = req_cnt;
        repeat (40) @(negedge clk);
        chk(req_cnt == r0, "R10 quiet after eol", req_cnt - r0, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1 act=%h exp=%h", 32'd1, 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule